// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Length

This block serialises characters for one asynchronous serial channel. Characters enter through a small holding FIFO. A frame begins on an edge of a 16x bit-rate tick enable supplied by a baud generator outside the block. Each frame has one start bit, then 5 to 8 data bits sent least significant bit first. An optional ninth cell follows for parity or for a multidrop address/data flag. The stop cell comes last, and its length is set in sixteenths of a bit. Every cell is timed by counting tick enables, and the line idles high.

The character length, parity mode, parity type and stop-length code are inputs to the block. They are captured when a character leaves the FIFO for the shift register, so each frame keeps the settings that were present when it started. Enable and disable command pulses decide whether new characters are accepted.

Two flow-control options are available:
- With clear-to-send gating on, a new frame starts only while the clear-to-send input is active.
- With automatic request-to-send on, the request output drops when the transmitter becomes completely empty.

Two status outputs report room in the FIFO and a fully empty transmitter.

Top module: `uart_frac_tx`

## Requirements
- R1: During and immediately after reset the line output is high, txEmt is 1, txRdy is 0 and rtsOut is 0.
- R2: A frame is a start cell held low for 16 ticks, followed by the data bits sent LSB first. Each data cell lasts 16 ticks. lenCode values 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. All mode inputs are captured when the frame starts.
- R3: With parMode=00, a parity cell follows the data. With parOdd=0 the number of ones in the data plus the parity bit is even. With parOdd=1 that number is odd.
- R4: With parMode=01, the parity cell carries the value of parOdd. With parMode=10, no parity cell is sent. With parMode=11, the parity cell carries the loadAddrFlag value that was loaded with the character.
- R5: The stop cell is high. For stopCode 0 to 7 it lasts 9+stopCode ticks. For stopCode 8 to 15 it lasts 17+stopCode ticks.
- R6: With 5-bit characters (lenCode=00), stopCode values 0 to 7 add 8 ticks to the stop cell. Codes 8 to 15 are unchanged.
- R7: A cmdEnable pulse enables the transmitter and a cmdDisable pulse disables it. If both pulses arrive in the same cycle, disable wins. While the transmitter is disabled, loads are ignored and txRdy is 0. Characters already held are still sent.
- R8: txRdy is 1 exactly when the transmitter is enabled and the FIFO (FIFO_DEPTH entries) has room. A load while the FIFO is full is ignored.
- R9: txEmt is 1 exactly when the FIFO is empty and no frame is in progress. It rises on the tick that ends the last stop cell.
- R10: With ctsCtrlEn=1, a frame starts only while ctsActive is 1. Held characters wait until ctsActive returns.
- R11: An rtsAssert pulse sets rtsOut. With rtsCtrlEn=1, rtsOut clears on the same clock edge that txEmt rises, and this clear takes priority over rtsAssert. With rtsCtrlEn=0, rtsOut stays set.
- R12: When another character is waiting at the end of a stop cell, its start cell begins on the very next tick, so the stop cell keeps its exact length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| cmdEnable | input | 1 | Enable command pulse |
| cmdDisable | input | 1 | Disable command pulse |
| loadValid | input | 1 | Load strobe for loadData |
| loadData | input | 8 | Character to send |
| loadAddrFlag | input | 1 | Address/data flag sent in wake-up mode |
| lenCode | input | 2 | Character length code |
| parMode | input | 2 | Parity mode: 00 normal, 01 forced, 10 none, 11 wake-up |
| parOdd | input | 1 | Parity type (0 even, 1 odd), or the forced parity value |
| stopCode | input | 4 | Stop-length code |
| ctsCtrlEn | input | 1 | Enables clear-to-send gating |
| ctsActive | input | 1 | Clear-to-send, active high |
| rtsCtrlEn | input | 1 | Enables automatic request-to-send drop |
| rtsAssert | input | 1 | Pulse that sets rtsOut |
| txLine | output | 1 | Serial line level |
| txRdy | output | 1 | FIFO has room and the transmitter is enabled |
| txEmt | output | 1 | FIFO empty and shifter idle |
| rtsOut | output | 1 | Request-to-send, active high |

## Verification
Two stop cases are the hardest to reach from the ports:
- The stop length of a frame that is directly followed by another one, with no idle tick between them.
- The stop length of the last frame, which has no following start edge to mark where it ends.

The monitor counts high tick slots after the final data or parity cell. It stops counting either at the next low slot or at the slot where txEmt first reads 1, so both endings are measured in ticks. Back-to-back frames are produced by loading several characters faster than they drain. A full FIFO is reached by holding clear-to-send inactive while loading more characters than the FIFO can hold.

// File: rtl/uart_frac_tx_pkg.sv
package uart_frac_tx_pkg;

  localparam int unsigned OVS = 16;
  localparam int unsigned STOP_W = $clog2(2 * OVS + 1);

  localparam logic [1:0] PAR_NORMAL = 2'b00;
  localparam logic [1:0] PAR_FORCE  = 2'b01;
  localparam logic [1:0] PAR_NONE   = 2'b10;
  localparam logic [1:0] PAR_WAKE   = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } txState_e;

  typedef struct packed {
    logic launch;
    logic nextBit;
    logic enterStop;
  } dpStrobes_t;

  typedef struct packed {
    logic [1:0] lenCode;
    logic [1:0] parMode;
    logic       parOdd;
    logic [3:0] stopCode;
  } frameCfg_t;

endpackage

// File: rtl/uart_frac_tx_fifo.sv
module uart_frac_tx_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [CW-1:0]    count;

  assign empty    = (count == '0);
  assign full     = (count == FULL_CNT);
  assign headData = store[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      end
      if (pop) begin
        rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      end
      if (push && !pop) begin
        count <= count + 1'b1;
      end else if (pop && !push) begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      store[wrPtr] <= wrData;
    end
  end

endmodule

// File: rtl/uart_frac_tx_dp.sv
module uart_frac_tx_dp
  import uart_frac_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CELL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  frameCfg_t         cfg,
  input  logic [DATA_W-1:0] headData,
  input  logic              headFlag,
  output logic              txLine,
  output logic [CELL_W-1:0] cellTotal,
  output logic [STOP_W-1:0] stopTicks
);

  localparam int unsigned FRAME_W    = DATA_W + 1;
  localparam int unsigned MIN_BITS   = DATA_W - 3;
  localparam int unsigned SHORT_BASE = OVS / 2 + 1;
  localparam int unsigned LONG_BASE  = OVS + 1;
  localparam int unsigned HALF_CELL  = OVS / 2;

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameNext;
  logic [FRAME_W-1:0] dataPad;
  logic [CELL_W-1:0]  nBits;
  logic               hasPar;
  logic               dataOnes;
  logic               parBit;
  logic [STOP_W-1:0]  stopNext;
  logic               lineReg;

  assign dataPad = {1'b1, headData};
  assign hasPar  = (cfg.parMode != PAR_NONE);

  always_comb begin
    nBits    = CELL_W'(MIN_BITS) + CELL_W'(cfg.lenCode);
    dataOnes = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CELL_W'(i) < nBits) begin
        dataOnes = dataOnes ^ headData[i];
      end
    end
  end

  always_comb begin
    unique case (cfg.parMode)
      PAR_NORMAL: parBit = dataOnes ^ cfg.parOdd;
      PAR_FORCE:  parBit = cfg.parOdd;
      PAR_WAKE:   parBit = headFlag;
      default:    parBit = 1'b1;
    endcase
  end

  always_comb begin
    for (int i = 0; i < FRAME_W; i++) begin
      if (CELL_W'(i) < nBits) begin
        frameNext[i] = dataPad[i];
      end else if (CELL_W'(i) == nBits) begin
        frameNext[i] = hasPar ? parBit : 1'b1;
      end else begin
        frameNext[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (cfg.stopCode[3]) begin
      stopNext = STOP_W'(LONG_BASE) + STOP_W'(cfg.stopCode);
    end else begin
      stopNext = STOP_W'(SHORT_BASE) + STOP_W'(cfg.stopCode);
      if (cfg.lenCode == 2'b00) begin
        stopNext = stopNext + STOP_W'(HALF_CELL);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '1;
      lineReg   <= 1'b1;
      cellTotal <= '0;
      stopTicks <= STOP_W'(OVS);
    end else if (strobes.launch) begin
      shiftReg  <= frameNext;
      lineReg   <= 1'b0;
      cellTotal <= nBits + CELL_W'(hasPar);
      stopTicks <= stopNext;
    end else if (strobes.nextBit) begin
      lineReg  <= shiftReg[0];
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end else if (strobes.enterStop) begin
      lineReg <= 1'b1;
    end
  end

  assign txLine = lineReg;

endmodule

// File: rtl/uart_frac_tx_ctrl.sv
module uart_frac_tx_ctrl
  import uart_frac_tx_pkg::*;
#(
  parameter int unsigned CELL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              loadValid,
  input  logic              ctsCtrlEn,
  input  logic              ctsActive,
  input  logic              rtsCtrlEn,
  input  logic              rtsAssert,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  input  logic [CELL_W-1:0] cellTotal,
  input  logic [STOP_W-1:0] stopTicks,
  output dpStrobes_t        strobes,
  output logic              push,
  output logic              pop,
  output logic              txRdy,
  output logic              txEmt,
  output logic              rtsOut
);

  localparam logic [STOP_W-1:0] CELL_LAST = STOP_W'(OVS - 1);

  txState_e          state;
  txState_e          stNext;
  logic [STOP_W-1:0] tickCnt;
  logic [STOP_W-1:0] cntNext;
  logic [CELL_W-1:0] cellsLeft;
  logic [CELL_W-1:0] leftNext;
  logic              enabled;
  logic              canStart;
  logic              goIdle;

  assign push     = loadValid && enabled && !fifoFull;
  assign canStart = !fifoEmpty && (!ctsCtrlEn || ctsActive);
  assign pop      = strobes.launch;
  assign txRdy    = enabled && !fifoFull;
  assign txEmt    = fifoEmpty && (state == ST_IDLE);

  always_comb begin
    stNext   = state;
    cntNext  = tickCnt;
    leftNext = cellsLeft;
    strobes  = '0;
    goIdle   = 1'b0;
    if (tick16) begin
      unique case (state)
        ST_IDLE: begin
          if (canStart) begin
            strobes.launch = 1'b1;
            stNext         = ST_START;
            cntNext        = '0;
          end
        end
        ST_START: begin
          if (tickCnt == CELL_LAST) begin
            strobes.nextBit = 1'b1;
            stNext          = ST_DATA;
            cntNext         = '0;
            leftNext        = cellTotal - 1'b1;
          end else begin
            cntNext = tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == CELL_LAST) begin
            cntNext = '0;
            if (cellsLeft == '0) begin
              strobes.enterStop = 1'b1;
              stNext            = ST_STOP;
            end else begin
              strobes.nextBit = 1'b1;
              leftNext        = cellsLeft - 1'b1;
            end
          end else begin
            cntNext = tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == stopTicks - 1'b1) begin
            cntNext = '0;
            if (canStart) begin
              strobes.launch = 1'b1;
              stNext         = ST_START;
            end else begin
              goIdle = 1'b1;
              stNext = ST_IDLE;
            end
          end else begin
            cntNext = tickCnt + 1'b1;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      cellsLeft <= '0;
    end else begin
      state     <= stNext;
      tickCnt   <= cntNext;
      cellsLeft <= leftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled <= 1'b0;
    end else if (cmdDisable) begin
      enabled <= 1'b0;
    end else if (cmdEnable) begin
      enabled <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsOut <= 1'b0;
    end else if (rtsCtrlEn && goIdle && fifoEmpty && !push) begin
      rtsOut <= 1'b0;
    end else if (rtsAssert) begin
      rtsOut <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
  import uart_frac_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  input  logic              loadAddrFlag,
  input  logic [1:0]        lenCode,
  input  logic [1:0]        parMode,
  input  logic              parOdd,
  input  logic [3:0]        stopCode,
  input  logic              ctsCtrlEn,
  input  logic              ctsActive,
  input  logic              rtsCtrlEn,
  input  logic              rtsAssert,
  output logic              txLine,
  output logic              txRdy,
  output logic              txEmt,
  output logic              rtsOut
);

  localparam int unsigned CELL_W = $clog2(DATA_W + 2);
  localparam int unsigned WORD_W = DATA_W + 1;

  dpStrobes_t        strobes;
  frameCfg_t         cfg;
  logic              push;
  logic              pop;
  logic              fifoEmpty;
  logic              fifoFull;
  logic [WORD_W-1:0] headWord;
  logic [CELL_W-1:0] cellTotal;
  logic [STOP_W-1:0] stopTicks;

  assign cfg = '{lenCode: lenCode, parMode: parMode, parOdd: parOdd, stopCode: stopCode};

  uart_frac_tx_fifo #(
    .WIDTH(WORD_W),
    .DEPTH(FIFO_DEPTH)
  ) fifo_i (
    .clk     (clk),
    .rstN    (rstN),
    .push    (push),
    .pop     (pop),
    .wrData  ({loadAddrFlag, loadData}),
    .headData(headWord),
    .empty   (fifoEmpty),
    .full    (fifoFull)
  );

  uart_frac_tx_ctrl #(
    .CELL_W(CELL_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .cmdEnable (cmdEnable),
    .cmdDisable(cmdDisable),
    .loadValid (loadValid),
    .ctsCtrlEn (ctsCtrlEn),
    .ctsActive (ctsActive),
    .rtsCtrlEn (rtsCtrlEn),
    .rtsAssert (rtsAssert),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .cellTotal (cellTotal),
    .stopTicks (stopTicks),
    .strobes   (strobes),
    .push      (push),
    .pop       (pop),
    .txRdy     (txRdy),
    .txEmt     (txEmt),
    .rtsOut    (rtsOut)
  );

  uart_frac_tx_dp #(
    .DATA_W(DATA_W),
    .CELL_W(CELL_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfg      (cfg),
    .headData (headWord[DATA_W-1:0]),
    .headFlag (headWord[DATA_W]),
    .txLine   (txLine),
    .cellTotal(cellTotal),
    .stopTicks(stopTicks)
  );

endmodule

// File: rtl/uart_frac_tx_chk.sv
module uart_frac_tx_chk (
  input logic clk,
  input logic rstN,
  input logic loadValid,
  input logic ctsCtrlEn,
  input logic ctsActive,
  input logic rtsCtrlEn,
  input logic txLine,
  input logic txRdy,
  input logic txEmt,
  input logic rtsOut
);

  // R1: outputs hold their idle values on the first edge after reset is released
  p_reset_values_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (txLine && txEmt && !txRdy && !rtsOut));

  // R7: a load presented while the transmitter is not ready leaves an empty transmitter empty
  p_ignore_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!txRdy && loadValid && txEmt) |=> txEmt);

  // R8: a load accepted while ready makes the transmitter non-empty
  p_load_taken_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txRdy && loadValid) |=> !txEmt);

  // R9: an empty transmitter holds the line at its idle level
  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    txEmt |-> txLine);

  // R10: a start edge only follows a cycle in which clear-to-send allowed it
  p_cts_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLine) |-> $past(!ctsCtrlEn || ctsActive));

  // R11: automatic request-to-send drops together with the rise of txEmt
  p_rts_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rtsCtrlEn) && $rose(txEmt)) |-> !rtsOut);

endmodule

bind uart_frac_tx uart_frac_tx_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .loadValid(loadValid),
  .ctsCtrlEn(ctsCtrlEn),
  .ctsActive(ctsActive),
  .rtsCtrlEn(rtsCtrlEn),
  .txLine   (txLine),
  .txRdy    (txRdy),
  .txEmt    (txEmt),
  .rtsOut   (rtsOut)
);

// File: tb/uart_frac_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frac_tx_tb_top;

  localparam int DEPTH = 4;
  localparam int TDIV  = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick16;
  logic       cmdEnable, cmdDisable, loadValid, loadAddrFlag;
  logic [7:0] loadData;
  logic [1:0] lenCode, parMode;
  logic       parOdd;
  logic [3:0] stopCode;
  logic       ctsCtrlEn, ctsActive, rtsCtrlEn, rtsAssert;
  logic       txLine, txRdy, txEmt, rtsOut;

  always #2 clk = ~clk;

  uart_frac_tx #(.DATA_W(8), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .loadValid(loadValid), .loadData(loadData), .loadAddrFlag(loadAddrFlag),
    .lenCode(lenCode), .parMode(parMode), .parOdd(parOdd), .stopCode(stopCode),
    .ctsCtrlEn(ctsCtrlEn), .ctsActive(ctsActive), .rtsCtrlEn(rtsCtrlEn), .rtsAssert(rtsAssert),
    .txLine(txLine), .txRdy(txRdy), .txEmt(txEmt), .rtsOut(rtsOut)
  );

  typedef struct {
    int data;
    int nBits;
    int hasPar;
    int parBit;
    int stop;
    int parReq;
    int stopReq;
  } expFrame_t;

  expFrame_t expQ[$];
  int checks = 0;
  int bad = 0;
  int framesSeen = 0;
  bit b2b = 0;
  bit done = 0;

  task automatic checkEq(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // tick generator: one enable every TDIV clocks
  int tickDiv;
  always @(negedge clk) begin
    if (!rstN) begin
      tickDiv <= 0;
      tick16  <= 1'b0;
    end else begin
      tickDiv <= (tickDiv == TDIV - 1) ? 0 : tickDiv + 1;
      tick16  <= (tickDiv == TDIV - 1);
    end
  end

  // scoreboard driver: expected frame from the requirements
  task automatic loadChar(input logic [7:0] d, input logic flag, input bit accept);
    expFrame_t e;
    int ones;
    e.nBits = 5 + int'(lenCode);
    e.data  = int'(d) & ((1 << e.nBits) - 1);
    ones = 0;
    for (int k = 0; k < e.nBits; k++) ones += (e.data >> k) & 1;
    e.hasPar = (parMode != 2'b10);
    case (parMode)
      2'b00: begin e.parBit = (ones % 2) ^ int'(parOdd); e.parReq = 3; end // R3
      2'b01: begin e.parBit = int'(parOdd); e.parReq = 4; end             // R4 forced
      2'b11: begin e.parBit = int'(flag); e.parReq = 4; end               // R4 wake-up
      default: begin e.parBit = 0; e.parReq = 4; end
    endcase
    if (stopCode >= 8) begin
      e.stop = 17 + int'(stopCode); e.stopReq = 5;                       // R5
    end else if (e.nBits == 5) begin
      e.stop = 17 + int'(stopCode); e.stopReq = 6;                       // R6
    end else begin
      e.stop = 9 + int'(stopCode); e.stopReq = 5;
    end
    if (b2b) e.stopReq = 12;                                             // R12
    if (accept) expQ.push_back(e);
    @(negedge clk);
    loadData = d; loadAddrFlag = flag; loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] l, input logic [1:0] pm, input logic po, input logic [3:0] sc);
    lenCode = l; parMode = pm; parOdd = po; stopCode = sc;
  endtask

  task automatic pulseEnable(); @(negedge clk); cmdEnable = 1; @(negedge clk); cmdEnable = 0; endtask
  task automatic pulseDisable(); @(negedge clk); cmdDisable = 1; @(negedge clk); cmdDisable = 0; endtask
  task automatic pulseRts(); @(negedge clk); rtsAssert = 1; @(negedge clk); rtsAssert = 0; endtask

  // monitor: samples the line once per tick slot
  int mState = 0;
  int s, stopCnt;
  bit [9:0] got;
  expFrame_t cur;

  task automatic startFrame();
    if (expQ.size() == 0) begin
      checks++; bad++;
      $display("FAIL R7 unexpected frame: actual=1 expected=0");
      cur = '{0, 8, 0, 0, 16, 4, 5};
    end else begin
      cur = expQ.pop_front();
    end
    s = 1;
    got = '0;
    mState = 1;
  endtask

  task automatic endFrame();
    int dg;
    dg = 0;
    for (int k = 0; k < cur.nBits; k++) dg |= int'(got[k]) << k;
    checkEq("R2", dg, cur.data, "data bits");
    if (cur.hasPar != 0) checkEq($sformatf("R%0d", cur.parReq), int'(got[cur.nBits]), cur.parBit, "parity cell");
    checkEq($sformatf("R%0d", cur.stopReq), stopCnt, cur.stop, "stop ticks");
    framesSeen++;
  endtask

  always @(negedge clk) begin
    if (rstN && tick16) begin
      case (mState)
        0: if (txLine == 1'b0) startFrame();
        1: begin
          s++;
          if (s % 16 == 8) begin
            if (s / 16 == 0) checkEq("R2", int'(txLine), 0, "start cell");
            else got[s / 16 - 1] = txLine;
          end
          if (s == 16 * (1 + cur.nBits + cur.hasPar)) begin
            mState = 2;
            stopCnt = 0;
          end
        end
        2: begin
          if (txLine == 1'b0 || txEmt) begin
            endFrame();
            if (txLine == 1'b0) startFrame();
            else mState = 0;
          end else begin
            stopCnt++;
          end
        end
        default: mState = 0;
      endcase
    end
  end

  task automatic waitIdle();
    do @(negedge clk); while (!(expQ.size() == 0 && txEmt && mState == 0));
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    int seen;
    rstN = 0; cmdEnable = 0; cmdDisable = 0; loadValid = 0; loadData = 0; loadAddrFlag = 0;
    ctsCtrlEn = 0; ctsActive = 0; rtsCtrlEn = 0; rtsAssert = 0;
    setMode(2'b11, 2'b10, 1'b0, 4'd7);
    repeat (5) @(negedge clk);
    checkEq("R1", int'(txLine), 1, "line in reset");
    checkEq("R1", int'(txEmt), 1, "txEmt in reset");
    checkEq("R1", int'(txRdy), 0, "txRdy in reset");
    checkEq("R1", int'(rtsOut), 0, "rtsOut in reset");
    rstN = 1;
    @(negedge clk);
    checkEq("R1", int'(txEmt && txLine && !txRdy && !rtsOut), 1, "idle after reset");

    // R7: load while disabled is ignored
    loadChar(8'h5A, 1'b0, 1'b0);
    repeat (200) @(negedge clk);
    checkEq("R7", int'(txEmt), 1, "txEmt after ignored load");
    checkEq("R7", framesSeen, 0, "frames after ignored load");
    checkEq("R7", int'(txRdy), 0, "txRdy while disabled");

    pulseEnable();
    checkEq("R8", int'(txRdy), 1, "txRdy after enable");

    // single frames over length, parity and stop settings
    setMode(2'b11, 2'b10, 1'b0, 4'd7);
    loadChar(8'hA5, 1'b0, 1'b1);
    checkEq("R9", int'(txEmt), 0, "txEmt after load");
    waitIdle();
    checkEq("R9", int'(txEmt), 1, "txEmt after drain");
    setMode(2'b10, 2'b00, 1'b0, 4'd0); loadChar(8'h35, 1'b0, 1'b1); waitIdle();
    setMode(2'b10, 2'b00, 1'b1, 4'd15); loadChar(8'h35, 1'b0, 1'b1); waitIdle();
    setMode(2'b11, 2'b00, 1'b0, 4'd4); loadChar(8'h01, 1'b0, 1'b1); waitIdle();
    setMode(2'b01, 2'b01, 1'b1, 4'd8); loadChar(8'h00, 1'b0, 1'b1); waitIdle();
    setMode(2'b01, 2'b01, 1'b0, 4'd2); loadChar(8'h3F, 1'b0, 1'b1); waitIdle();
    setMode(2'b00, 2'b10, 1'b0, 4'd0); loadChar(8'h15, 1'b0, 1'b1); waitIdle();
    setMode(2'b00, 2'b00, 1'b1, 4'd7); loadChar(8'h0B, 1'b0, 1'b1); waitIdle();
    setMode(2'b00, 2'b10, 1'b0, 4'd8); loadChar(8'h1E, 1'b0, 1'b1); waitIdle();
    setMode(2'b11, 2'b11, 1'b0, 4'd5); loadChar(8'hC3, 1'b1, 1'b1); waitIdle();
    setMode(2'b11, 2'b11, 1'b1, 4'd5); loadChar(8'hC3, 1'b0, 1'b1); waitIdle();

    // R12: back-to-back frames keep exact stop length
    setMode(2'b11, 2'b10, 1'b0, 4'd3);
    b2b = 1;
    loadChar(8'h81, 1'b0, 1'b1);
    loadChar(8'h7E, 1'b0, 1'b1);
    loadChar(8'h55, 1'b0, 1'b1);
    waitIdle();
    b2b = 0;

    // R10 and R8: CTS holds the FIFO full, extra load dropped
    ctsCtrlEn = 1; ctsActive = 0;
    seen = framesSeen;
    for (int k = 0; k < DEPTH; k++) loadChar(8'(8'h10 + k), 1'b0, 1'b1);
    checkEq("R8", int'(txRdy), 0, "txRdy with full FIFO");
    loadChar(8'hEE, 1'b0, 1'b0);
    repeat (400) @(negedge clk);
    checkEq("R10", framesSeen, seen, "frames while CTS inactive");
    checkEq("R10", int'(txEmt), 0, "txEmt while held");
    checkEq("R10", int'(txLine), 1, "line while held");
    ctsActive = 1;
    waitIdle();
    checkEq("R10", framesSeen, seen + DEPTH, "frames after CTS active");
    ctsCtrlEn = 0;

    // R11: automatic request-to-send drop
    rtsCtrlEn = 1;
    pulseRts();
    checkEq("R11", int'(rtsOut), 1, "rtsOut after assert");
    loadChar(8'h96, 1'b0, 1'b1);
    do @(negedge clk); while (!txEmt);
    checkEq("R11", int'(rtsOut), 0, "rtsOut when empty");
    waitIdle();
    rtsCtrlEn = 0;
    pulseRts();
    loadChar(8'h69, 1'b0, 1'b1);
    waitIdle();
    checkEq("R11", int'(rtsOut), 1, "rtsOut without auto control");

    // R7: disable command blocks loads again
    pulseDisable();
    checkEq("R7", int'(txRdy), 0, "txRdy after disable");
    seen = framesSeen;
    loadChar(8'h33, 1'b0, 1'b0);
    repeat (300) @(negedge clk);
    checkEq("R7", int'(txEmt), 1, "txEmt after disabled load");
    checkEq("R7", framesSeen, seen, "frames after disabled load");

    finishRun();
  end

endmodule